// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper for One H-Bridge

This block regulates the current in one motor winding by switching the four transistors of an H-bridge. Each regulation cycle starts with an on period. The diagonal transistor pair picked by the polarity input conducts until an external current comparator reports that the setpoint has been reached. The comparator is not looked at during a blanking window at the start of each on period, so that window is also the shortest on-time. After a trip, the bridge spends a fixed number of clock cycles in decay and then starts the next on period.

Three decay behaviours can be selected at the trip. In slow decay, current circulates through the low side. In fast decay, current is returned against the supply. In mixed decay, the bridge runs fast decay for the first part of the off period and slow decay for the rest. When synchronous rectification is allowed, the transistors that would otherwise leave the current to the body diodes are switched on. A zero-current indication switches them off again for the rest of the off period. A disable input and a fault input darken the bridge while the timing keeps running. A safety override switches both low sides on and both high sides off, and it wins over every other input. Every gate change passes through a per-leg dead-time stage, so the two transistors of one leg are never both on.

Top module: `hb_chopper`

## Requirements
- R1: While reset is asserted, and during the first cycle after it is released, all four gates are off. The first on period begins one cycle after release, and its gates appear one cycle later still.
- R2: During an on period, polarity 1 turns on the leg-A high side and the leg-B low side. Polarity 0 turns on the leg-B high side and the leg-A low side.
- R3: A trip is ignored during the first BLANK_CYC cycles of every on period, so an on period lasts at least BLANK_CYC+1 cycles. The first trip seen after that ends the on period.
- R4: An off period lasts exactly OFF_CYC cycles and is followed by a new on period. Polarity is sampled once, when each on period is entered.
- R5: Slow decay (decay code 00 or 11): the sink-leg low side stays on and the source high side turns off. With synchronous rectification, the source-leg low side also turns on.
- R6: Fast decay (code 01): both driving transistors turn off. With synchronous rectification, the opposite diagonal (source low side, sink high side) turns on. Without it, no transistor is on.
- R7: Mixed decay (code 10) behaves as fast decay for the first FAST_CYC cycles of the off period and as slow decay for the rest.
- R8: The decay code is sampled in the cycle the trip is accepted and holds for the whole off period. Later changes have no effect until the next trip.
- R9: With sr_off high, no rectifying transistor is switched on during decay. At most one gate is on in the off period.
- R10: A zero_det pulse during an off period removes the rectifying transistors at once and keeps them off until the off period ends.
- R11: bridge_off or fault_off high turns all four gates off within one cycle, while on/off timing continues undisturbed.
- R12: ovr_safe high turns both high sides off within one cycle and turns both low sides on. It takes priority over every other input.
- R13: Within one leg the two gates are never on together. A gate turns on only after both gates of its leg have been off for at least DEAD_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_trip | input | 1 | Current comparator: setpoint reached |
| zero_det | input | 1 | Winding current has reached zero |
| decay_sel | input | 2 | Decay code: 00/11 slow, 01 fast, 10 mixed |
| pol | input | 1 | Drive polarity: 1 sources from leg A, 0 from leg B |
| sr_off | input | 1 | High disables synchronous rectification |
| bridge_off | input | 1 | High turns all gates off |
| fault_off | input | 1 | Fault disable, same effect as bridge_off |
| ovr_safe | input | 1 | Safety override: low sides on, high sides off |
| gate_ah | output | 1 | Leg-A high-side gate |
| gate_al | output | 1 | Leg-A low-side gate |
| gate_bh | output | 1 | Leg-B high-side gate |
| gate_bl | output | 1 | Leg-B low-side gate |

## Verification
The chopper is first driven with the comparator held high. This pins every on period to its shortest length and exposes the off-period count and the polarity sampling point. Sparse random trips then show whether the blank window ignores early trips and accepts later ones. Each decay code is run alone, then changed every cycle, to tell slow, fast and the mixed split apart and to show that the code is held from the trip. Runs with rectification switched off, with zero-current pulses, with disable and fault pulses and with override pulses separate the gating priorities. All of these are layered together with the dead-time stage busy on every transition.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_ON    = 2'd1,
    PH_OFF   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'd0,
    DK_FAST  = 2'd1,
    DK_MIXED = 2'd2
  } decay_t;

  // Map the raw decay code; the unused code falls back to slow decay.
  function automatic decay_t decode_decay(logic [1:0] code);
    case (code)
      2'b01:   return DK_FAST;
      2'b10:   return DK_MIXED;
      default: return DK_SLOW;
    endcase
  endfunction

  // True while the off period should return current against the supply.
  function automatic logic fast_window(decay_t mode, int unsigned elapsed,
                                       int unsigned fast_len);
    return (mode == DK_FAST) || ((mode == DK_MIXED) && (elapsed < fast_len));
  endfunction

endpackage

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 4750,
  parameter int BLANK_CYC = 119
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip,
  input  logic          pol_in,
  input  logic [1:0]    decay_in,
  output phase_t        ph,
  output logic [$clog2(((OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC) + 2)-1:0] cnt,
  output logic          pol_q,
  output decay_t        mode_q
);
  localparam int MAXV = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int PW   = $clog2(MAXV + 2);
  localparam logic [PW-1:0] OFF_LAST  = PW'(OFF_CYC - 1);
  localparam logic [PW-1:0] BLANK_LIM = PW'(BLANK_CYC);

  logic trip_take;
  logic off_done;

  assign trip_take = (ph == PH_ON) && (cnt >= BLANK_LIM) && trip;
  assign off_done  = (ph == PH_OFF) && (cnt == OFF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_START;
      cnt    <= '0;
      pol_q  <= 1'b0;
      mode_q <= DK_SLOW;
    end else begin
      case (ph)
        PH_START: begin
          ph    <= PH_ON;
          cnt   <= '0;
          pol_q <= pol_in;
        end
        PH_ON: begin
          if (trip_take) begin
            ph     <= PH_OFF;
            cnt    <= '0;
            mode_q <= decode_decay(decay_in);
          end else if (cnt < BLANK_LIM) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_OFF: begin
          if (off_done) begin
            ph    <= PH_ON;
            cnt   <= '0;
            pol_q <= pol_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_START;
      endcase
    end
  end

  // Checker counters: lengths of the present on and off stretches.
  logic [PW-1:0] on_len;
  logic [PW-1:0] off_len;
  localparam logic [PW-1:0] ON_SAT  = PW'(BLANK_CYC + 1);
  localparam logic [PW-1:0] OFF_SAT = PW'(OFF_CYC + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len  <= '0;
      off_len <= '0;
    end else begin
      on_len  <= (ph != PH_ON) ? '0 : ((on_len == ON_SAT) ? on_len : on_len + 1'b1);
      off_len <= (ph != PH_OFF) ? '0 : ((off_len == OFF_SAT) ? off_len : off_len + 1'b1);
    end
  end

  AST_BLANK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFF && $past(ph) == PH_ON) |-> (on_len == ON_SAT)); // R3

  AST_OFF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ON && $past(ph) == PH_OFF) |-> (off_len == PW'(OFF_CYC))); // R4

endmodule

// File: rtl/chop_leg.sv
module chop_leg #(
  parameter int DEAD_CYC = 59
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  output logic fet_hi,
  output logic fet_lo
);
  localparam int DW = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0] DEAD_LD   = DW'(DEAD_CYC);
  localparam logic [DW-1:0] DARK_SAT  = DW'(DEAD_CYC + 1);

  logic [DW-1:0] gap;
  logic hi_drop, lo_drop, gap_busy;

  assign hi_drop  = fet_hi && !want_hi;
  assign lo_drop  = fet_lo && !want_lo;
  assign gap_busy = (gap != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fet_hi <= 1'b0;
      fet_lo <= 1'b0;
      gap    <= '0;
    end else if (hi_drop) begin
      fet_hi <= 1'b0;
      gap    <= DEAD_LD;
    end else if (lo_drop) begin
      fet_lo <= 1'b0;
      gap    <= DEAD_LD;
    end else if (gap_busy) begin
      gap <= gap - 1'b1;
    end else if (want_hi && !fet_lo) begin
      fet_hi <= 1'b1;
    end else if (want_lo && !fet_hi) begin
      fet_lo <= 1'b1;
    end
  end

  // Checker: consecutive cycles with the whole leg dark (saturating).
  logic [DW-1:0] dark_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dark_run <= DARK_SAT;
    else if (fet_hi || fet_lo)  dark_run <= '0;
    else if (dark_run != DARK_SAT) dark_run <= dark_run + 1'b1;
  end

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fet_hi && fet_lo)); // R13

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fet_hi) || $rose(fet_lo)) |-> (dark_run == DARK_SAT)); // R13

endmodule

// File: rtl/hb_chopper.sv
module hb_chopper
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 4750,
  parameter int BLANK_CYC = 119,
  parameter int FAST_CYC  = 1500,
  parameter int DEAD_CYC  = 59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_trip,
  input  logic       zero_det,
  input  logic [1:0] decay_sel,
  input  logic       pol,
  input  logic       sr_off,
  input  logic       bridge_off,
  input  logic       fault_off,
  input  logic       ovr_safe,
  output logic       gate_ah,
  output logic       gate_al,
  output logic       gate_bh,
  output logic       gate_bl
);
  localparam int MAXV = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int PW   = $clog2(MAXV + 2);

  phase_t        ph;
  logic [PW-1:0] ph_cnt;
  logic          pol_q;
  decay_t        mode_q;

  chop_phase #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip    (cmp_trip),
    .pol_in  (pol),
    .decay_in(decay_sel),
    .ph      (ph),
    .cnt     (ph_cnt),
    .pol_q   (pol_q),
    .mode_q  (mode_q)
  );

  // Zero-current memory, cleared outside the off period.
  logic zero_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              zero_seen <= 1'b0;
    else if (ph != PH_OFF)   zero_seen <= 1'b0;
    else if (zero_det)       zero_seen <= 1'b1;
  end

  logic in_off, in_fast, sync_ok, dark;
  logic src, snk;
  logic [1:0] req_hi, req_lo;

  assign in_off  = (ph == PH_OFF);
  assign in_fast = fast_window(mode_q, {{(32-PW){1'b0}}, ph_cnt}, FAST_CYC);
  assign sync_ok = !sr_off && !zero_seen && !zero_det;
  assign dark    = bridge_off || fault_off;
  assign src     = !pol_q;   // index 0 = leg A, 1 = leg B
  assign snk     = pol_q;

  always_comb begin
    req_hi = '0;
    req_lo = '0;
    if (ph == PH_ON) begin
      req_hi[src] = 1'b1;
      req_lo[snk] = 1'b1;
    end else if (in_off) begin
      if (in_fast) begin
        if (sync_ok) begin
          req_lo[src] = 1'b1;
          req_hi[snk] = 1'b1;
        end
      end else begin
        req_lo[snk] = 1'b1;
        if (sync_ok) req_lo[src] = 1'b1;
      end
    end
    if (dark) begin
      req_hi = '0;
      req_lo = '0;
    end
    if (ovr_safe) begin
      req_hi = '0;
      req_lo = 2'b11;
    end
  end

  logic [1:0] g_hi, g_lo;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_leg
      chop_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_hi(req_hi[g]),
        .want_lo(req_lo[g]),
        .fet_hi (g_hi[g]),
        .fet_lo (g_lo[g])
      );
    end
  endgenerate

  assign gate_ah = g_hi[0];
  assign gate_al = g_lo[0];
  assign gate_bh = g_hi[1];
  assign gate_bl = g_lo[1];

  AST_OVR_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_safe |=> (!gate_ah && !gate_bh)); // R12

  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (dark && !ovr_safe) |=> !(gate_ah || gate_al || gate_bh || gate_bl)); // R11

  AST_NO_RECT_SR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_off && sr_off && !ovr_safe) |=>
      ($countones({gate_ah, gate_al, gate_bh, gate_bl}) <= 1)); // R9

endmodule

// File: tb/hb_chopper_tb_top.sv
module hb_chopper_tb_top;
  localparam int OFF = 20, BLK = 6, FST = 7, DT = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmp_trip = 0, zero_det = 0, pol = 1, sr_off = 0;
  logic bridge_off = 0, fault_off = 0, ovr_safe = 0;
  logic [1:0] decay_sel = 2'b00;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  hb_chopper #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .FAST_CYC(FST), .DEAD_CYC(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_trip(cmp_trip), .zero_det(zero_det),
    .decay_sel(decay_sel), .pol(pol), .sr_off(sr_off), .bridge_off(bridge_off),
    .fault_off(fault_off), .ovr_safe(ovr_safe),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl));

  int n_cmp = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;
  string cur_tag = "R1";

  // Reference model state: phase 0 start, 1 driving, 2 decaying.
  int m_ph, m_t, m_md;
  bit m_pol, m_z;
  bit m_h[2], m_l[2];
  int m_cd[2];

  // Gate word {A high, A low, B high, B low} demanded by the requirements.
  function automatic logic [3:0] want_word(int ph, int el, bit pl, int md, bit syn);
    bit fast;
    if (ph == 1) return pl ? 4'b1001 : 4'b0110;
    if (ph != 2) return 4'b0000;
    fast = (md == 1) || (md == 2 && el < FST);
    if (fast) return syn ? (pl ? 4'b0110 : 4'b1001) : 4'b0000;
    if (syn) return 4'b0101;
    return pl ? 4'b0001 : 4'b0100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_md = 0; m_pol = 0; m_z = 0;
      for (int i = 0; i < 2; i++) begin m_h[i] = 0; m_l[i] = 0; m_cd[i] = 0; end
    end else begin
      logic [3:0] w;
      bit wh, wl;
      w = want_word(m_ph, OFF - m_t, m_pol, m_md, !sr_off && !m_z && !zero_det);
      if (bridge_off || fault_off) w = 4'b0000;
      if (ovr_safe) w = 4'b0101;
      for (int i = 0; i < 2; i++) begin
        wh = (i == 0) ? w[3] : w[1];
        wl = (i == 0) ? w[2] : w[0];
        if (m_h[i] && !wh)      begin m_h[i] = 0; m_cd[i] = DT; end
        else if (m_l[i] && !wl) begin m_l[i] = 0; m_cd[i] = DT; end
        else if (m_cd[i] > 0)   m_cd[i]--;
        else if (wh && !m_l[i]) m_h[i] = 1;
        else if (wl && !m_h[i]) m_l[i] = 1;
      end
      if (m_ph == 2 && zero_det) m_z = 1;
      if (m_ph != 2) m_z = 0;
      case (m_ph)
        0: begin m_ph = 1; m_t = 0; m_pol = pol; end
        1: if (m_t >= BLK && cmp_trip) begin
             m_ph = 2; m_t = OFF;
             m_md = (decay_sel == 2'b01) ? 1 : (decay_sel == 2'b10) ? 2 : 0;
           end else m_t++;
        default: if (m_t == 1) begin m_ph = 1; m_t = 0; m_pol = pol; end
                 else m_t--;
      endcase
      if (m_ph == 2 && zero_det && m_t == OFF) m_z = 0;
    end
  end

  task automatic check_word(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {gate_ah, gate_al, gate_bh, gate_bl};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s gates actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done)
      check_word(cur_tag, {m_h[0], m_l[0], m_h[1], m_l[1]});
  end

  // Knobs: percentages and fixed/random choices (value 9 means random).
  int k_trip, k_pol, k_dec, k_sr, k_zero, k_dis, k_flt, k_ovr;

  task automatic run(string tag, int n);
    cur_tag = tag;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cmp_trip   = ($urandom_range(99) < k_trip);
      pol        = (k_pol == 9) ? 1'($urandom_range(1)) : 1'(k_pol);
      decay_sel  = (k_dec == 9) ? 2'($urandom_range(3)) : 2'(k_dec);
      sr_off     = (k_sr == 9) ? 1'($urandom_range(1)) : 1'(k_sr);
      zero_det   = ($urandom_range(99) < k_zero);
      bridge_off = ($urandom_range(99) < k_dis);
      fault_off  = ($urandom_range(99) < k_flt);
      ovr_safe   = ($urandom_range(99) < k_ovr);
    end
  endtask

  task automatic knobs(int tr, int pl, int dc, int sr, int zr, int ds, int fl, int ov);
    k_trip = tr; k_pol = pl; k_dec = dc; k_sr = sr;
    k_zero = zr; k_dis = ds; k_flt = fl; k_ovr = ov;
  endtask

  initial begin
    void'($urandom(17));
    repeat (5) @(negedge clk);
    check_word("R1", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_word("R1", 4'b0000);
    @(negedge clk);
    check_word("R1", 4'b1001);
    cmp_on = 1;
    knobs(100, 1, 0, 0, 0, 0, 0, 0);  run("R2", 80);
    knobs(100, 0, 0, 0, 0, 0, 0, 0);  run("R2", 80);
    knobs(30, 9, 0, 0, 0, 0, 0, 0);   run("R3", 250);
    knobs(100, 9, 0, 0, 0, 0, 0, 0);  run("R4", 200);
    knobs(40, 9, 0, 0, 0, 0, 0, 0);   run("R5", 250);
    knobs(40, 9, 3, 0, 0, 0, 0, 0);   run("R5", 150);
    knobs(40, 9, 1, 0, 0, 0, 0, 0);   run("R6", 250);
    knobs(40, 9, 2, 0, 0, 0, 0, 0);   run("R7", 300);
    knobs(40, 9, 9, 0, 0, 0, 0, 0);   run("R8", 400);
    knobs(40, 9, 9, 1, 0, 0, 0, 0);   run("R9", 300);
    knobs(40, 9, 9, 0, 8, 0, 0, 0);   run("R10", 400);
    knobs(40, 9, 9, 9, 5, 12, 8, 0);  run("R11", 500);
    knobs(40, 9, 9, 9, 5, 10, 5, 10); run("R12", 500);
    knobs(100, 9, 9, 0, 0, 0, 0, 50); run("R12", 200);
    knobs(35, 9, 9, 9, 5, 5, 3, 3);   run("R13", 3000);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL %s watchdog expired actual=running expected=finished", cur_tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule